// File: doc/BRIEF.md
# Two-Domain Bus Mastership Arbiter

This block decides bus ownership for two independent resources. On the internal bus, four masters compete: a DMA engine that can also reach the external bus, a second DMA engine, a data-transfer controller and the CPU. The order between them is fixed. On the external bus, the block orders a memory refresh engine, the external-bus DMA engine, a request to release the bus to an outside master, and an external access by whichever other internal master currently owns the internal bus. The two domains grant in parallel.

Every requester raises a request line and gets back a registered acknowledge. It keeps that acknowledge for as long as it holds its request, and is never pre-empted. A configuration input chooses how refresh shares the external bus. In shared mode, refresh may overlap with the DMA engine's external access and with a non-DRAM access by an internal master. In serialized mode, refresh takes its turn in a single one-hot external order.

Top module: `mstr_arbiter`

## Requirements
- R1: While reset is asserted, and until the first request after reset, every acknowledge output is 0.
- R2: On the internal bus, a grant goes to the highest-priority requester. The order from highest to lowest is xdma, dma, dtc, cpu. The acknowledge rises one clock edge after the request is seen.
- R3: At most one internal acknowledge is high in any cycle.
- R4: A holder keeps its acknowledge in both domains while its request stays high, even if a higher-priority requester appears. A lower-priority requester that is waiting takes over at the same edge at which the holder's dropped request is seen.
- R5: An acknowledge is only ever high in the cycle after its request was high. With no other requester, it falls one edge after the request drops.
- R6: When `cfg_ref_serial` is 1, at most one external acknowledge is high. New external grants follow the order ref, xdma, rel, mst, from highest to lowest.
- R7: `mst_xreq` is considered only while one of `ack_dma`, `ack_dtc` or `ack_cpu` is high at the arbitration edge.
- R8: When `cfg_ref_serial` is 0, `ref_ack` may be high together with `xdma_xack`, or together with `mst_xack` for an access flagged non-DRAM (`mst_dram` = 0).
- R9: When `cfg_ref_serial` is 0, `ref_ack` is never high together with `rel_ack`, or with a held `mst_xack` whose access is flagged DRAM. When refresh and one of these conflicting requests both seek a fresh grant at the same edge, refresh wins.
- R10: When `cfg_ref_serial` is 0, `xdma_xack`, `rel_ack` and `mst_xack` form a one-hot slot with the order xdma, rel, mst.
- R11: A change of `cfg_ref_serial` takes effect only at an edge where no external acknowledge is held. Until then, the previous mode stays in force.
- R12: The xdma master can hold `ack_xdma` and `xdma_xack` at the same time, because the two domains decide independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_xdma | input | 1 | Internal-bus request, external-capable DMA engine |
| req_dma | input | 1 | Internal-bus request, DMA engine |
| req_dtc | input | 1 | Internal-bus request, data-transfer controller |
| req_cpu | input | 1 | Internal-bus request, CPU |
| ack_xdma | output | 1 | Internal-bus grant, external-capable DMA engine |
| ack_dma | output | 1 | Internal-bus grant, DMA engine |
| ack_dtc | output | 1 | Internal-bus grant, data-transfer controller |
| ack_cpu | output | 1 | Internal-bus grant, CPU |
| cfg_ref_serial | input | 1 | 1: refresh serialized with all external work; 0: shared mode |
| ref_req | input | 1 | Refresh request |
| xdma_xreq | input | 1 | External-bus request by the external-capable DMA engine |
| rel_req | input | 1 | Request to release the external bus |
| mst_xreq | input | 1 | External access by the current internal owner |
| mst_dram | input | 1 | That external access targets DRAM |
| ref_ack | output | 1 | Refresh grant |
| xdma_xack | output | 1 | External-bus grant, DMA engine |
| rel_ack | output | 1 | Bus release grant |
| mst_xack | output | 1 | External-access grant, internal owner |

## Verification
Some rules are checked by assertions on every cycle: internal one-hot, serialized-mode external one-hot, the refresh/release exclusion, grants only to requesters, holders never losing a live grant, mode frozen while the external domain is busy, and the gating of the internal owner's external request. Only the bench's scenarios can show the choices themselves. These are the priority order when several requests arrive together, the same-edge handoff to a waiting master, which pairs overlap in shared mode, refresh beating a DRAM access that arrives with it, and the deferred mode change.

// File: rtl/mstr_pkg.sv
package mstr_pkg;
  localparam int unsigned INT_N = 4;
  localparam int unsigned EXT_N = 4;
  // internal slot order equals priority (lowest index wins)
  localparam int unsigned I_XDMA = 0;
  localparam int unsigned I_DMA  = 1;
  localparam int unsigned I_DTC  = 2;
  localparam int unsigned I_CPU  = 3;
  // external slot order equals serialized priority
  localparam int unsigned E_REF  = 0;
  localparam int unsigned E_XDMA = 1;
  localparam int unsigned E_REL  = 2;
  localparam int unsigned E_MST  = 3;
  typedef logic [INT_N-1:0] int_vec_t;
  typedef logic [EXT_N-1:0] ext_vec_t;
endpackage

// File: rtl/mstr_pick.sv
// Fixed-priority selector with hold: a live holder keeps the grant,
// otherwise the lowest-index unblocked requester is chosen.
module mstr_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] held,
  input  logic [N-1:0] blk,
  output logic [N-1:0] nxt
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] live;
  logic [N-1:0] cand;
  logic [N-1:0] first;

  always_comb begin
    live  = held & req;
    cand  = req & ~blk;
    first = cand & (~cand + ONE);
    nxt   = (|live) ? held : first;
  end
endmodule

// File: rtl/mstr_int_dom.sv
module mstr_int_dom
  import mstr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  int_vec_t req,
  output int_vec_t ack
);
  int_vec_t ack_q;
  int_vec_t ack_nxt;
  logic     ack_en;

  mstr_pick #(.N(INT_N)) u_pick (
    .req  (req),
    .held (ack_q),
    .blk  ('0),
    .nxt  (ack_nxt)
  );

  always_comb begin
    ack_en = (ack_nxt != ack_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
    end else if (ack_en) begin
      ack_q <= ack_nxt;
    end
  end

  assign ack = ack_q;

  // R3
  int_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_q));

  // R4
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_q & req)) |=> (ack_q == $past(ack_q)));

  // R5
  for (genvar g = 0; g < INT_N; g++) begin : g_int_req
    int_gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q[g] |-> $past(req[g]));
  end
endmodule

// File: rtl/mstr_ext_dom.sv
module mstr_ext_dom
  import mstr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ext_vec_t req,
  input  logic     mst_dram,
  input  logic     cfg_serial,
  output ext_vec_t ack
);
  ext_vec_t   ack_q;
  ext_vec_t   ack_nxt;
  ext_vec_t   ser_nxt;
  logic [2:0] main_nxt;
  logic [2:0] main_blk;
  logic       idle;
  logic       mode_q;
  logic       mode_eff;
  logic       ref_blk;
  logic       ref_nxt;
  logic       ack_en;

  always_comb begin
    idle     = ~|ack_q;
    mode_eff = idle ? cfg_serial : mode_q;
  end

  // serialized mode: one-hot over all four, ref first
  mstr_pick #(.N(EXT_N)) u_ser (
    .req  (req),
    .held (ack_q),
    .blk  ('0),
    .nxt  (ser_nxt)
  );

  // shared mode: refresh slot decided first, then the one-hot main slot
  always_comb begin
    ref_blk  = (ack_q[E_REL] & req[E_REL]) |
               (ack_q[E_MST] & req[E_MST] & mst_dram);
    ref_nxt  = req[E_REF] & (ack_q[E_REF] | ~ref_blk);
    main_blk = {ref_nxt & mst_dram, ref_nxt, 1'b0};
  end

  mstr_pick #(.N(3)) u_main (
    .req  (req[E_MST:E_XDMA]),
    .held (ack_q[E_MST:E_XDMA]),
    .blk  (main_blk),
    .nxt  (main_nxt)
  );

  always_comb begin
    ack_nxt = mode_eff ? ser_nxt : {main_nxt, ref_nxt};
    ack_en  = (ack_nxt != ack_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
    end else if (ack_en) begin
      ack_q <= ack_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
    end else if (idle) begin
      mode_q <= cfg_serial;
    end
  end

  assign ack = ack_q;

  // R6
  ext_serial_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> $onehot0(ack_q));

  // R9
  ext_ref_rel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_q[E_REF] && ack_q[E_REL]));

  // R10
  ext_main_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_q[E_MST:E_XDMA]));

  // R4
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_q & req)) |=> ((ack_q & $past(ack_q & req)) == $past(ack_q & req)));

  // R11
  ext_mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_q) |=> $stable(mode_q));

  // R5
  for (genvar g = 0; g < EXT_N; g++) begin : g_ext_req
    ext_gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q[g] |-> $past(req[g]));
  end
endmodule

// File: rtl/mstr_arbiter.sv
module mstr_arbiter
  import mstr_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_xdma,
  input  logic req_dma,
  input  logic req_dtc,
  input  logic req_cpu,
  output logic ack_xdma,
  output logic ack_dma,
  output logic ack_dtc,
  output logic ack_cpu,
  input  logic cfg_ref_serial,
  input  logic ref_req,
  input  logic xdma_xreq,
  input  logic rel_req,
  input  logic mst_xreq,
  input  logic mst_dram,
  output logic ref_ack,
  output logic xdma_xack,
  output logic rel_ack,
  output logic mst_xack
);
  logic [RST_STAGES-1:0] rst_sh;
  logic                  rst_sync_n;
  int_vec_t              int_req;
  int_vec_t              int_ack;
  ext_vec_t              ext_req;
  ext_vec_t              ext_ack;
  logic                  owner_ok;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh <= '0;
    end else begin
      rst_sh <= {rst_sh[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sh[RST_STAGES-1];

  always_comb begin
    int_req          = '0;
    int_req[I_XDMA]  = req_xdma;
    int_req[I_DMA]   = req_dma;
    int_req[I_DTC]   = req_dtc;
    int_req[I_CPU]   = req_cpu;
    owner_ok         = int_ack[I_DMA] | int_ack[I_DTC] | int_ack[I_CPU];
    ext_req          = '0;
    ext_req[E_REF]   = ref_req;
    ext_req[E_XDMA]  = xdma_xreq;
    ext_req[E_REL]   = rel_req;
    ext_req[E_MST]   = mst_xreq & owner_ok;
  end

  mstr_int_dom u_int (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (int_req),
    .ack   (int_ack)
  );

  mstr_ext_dom u_ext (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req        (ext_req),
    .mst_dram   (mst_dram),
    .cfg_serial (cfg_ref_serial),
    .ack        (ext_ack)
  );

  assign ack_xdma  = int_ack[I_XDMA];
  assign ack_dma   = int_ack[I_DMA];
  assign ack_dtc   = int_ack[I_DTC];
  assign ack_cpu   = int_ack[I_CPU];
  assign ref_ack   = ext_ack[E_REF];
  assign xdma_xack = ext_ack[E_XDMA];
  assign rel_ack   = ext_ack[E_REL];
  assign mst_xack  = ext_ack[E_MST];

  // R7
  mst_owner_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mst_xack) |-> $past(ack_dma || ack_dtc || ack_cpu));
endmodule

// File: tb/mstr_arbiter_tb.sv
module mstr_arbiter_tb;
  logic clk;
  logic rst_n;
  logic req_xdma, req_dma, req_dtc, req_cpu;
  logic ack_xdma, ack_dma, ack_dtc, ack_cpu;
  logic cfg_ref_serial, ref_req, xdma_xreq, rel_req, mst_xreq, mst_dram;
  logic ref_ack, xdma_xack, rel_ack, mst_xack;

  int errors = 0;
  int checks = 0;

  mstr_arbiter u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_xdma(req_xdma), .req_dma(req_dma), .req_dtc(req_dtc), .req_cpu(req_cpu),
    .ack_xdma(ack_xdma), .ack_dma(ack_dma), .ack_dtc(ack_dtc), .ack_cpu(ack_cpu),
    .cfg_ref_serial(cfg_ref_serial), .ref_req(ref_req), .xdma_xreq(xdma_xreq),
    .rel_req(rel_req), .mst_xreq(mst_xreq), .mst_dram(mst_dram),
    .ref_ack(ref_ack), .xdma_xack(xdma_xack), .rel_ack(rel_ack), .mst_xack(mst_xack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // observed vector: [7:4] = {cpu,dtc,dma,xdma}, [3:0] = {mst,rel,xdma,ref}
  function automatic logic [7:0] obs();
    return {ack_cpu, ack_dtc, ack_dma, ack_xdma, mst_xack, rel_ack, xdma_xack, ref_ack};
  endfunction

  task automatic chk(input string tag, input logic [7:0] exp);
    logic [7:0] got;
    got = obs();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drop_all();
    req_xdma = 0; req_dma = 0; req_dtc = 0; req_cpu = 0;
    ref_req = 0; xdma_xreq = 0; rel_req = 0; mst_xreq = 0; mst_dram = 0;
  endtask

  // reference model, derived from the requirements
  function automatic logic [3:0] pick(input logic [3:0] req, input logic [3:0] held,
                                      input logic [3:0] blk, input int n);
    for (int i = 0; i < n; i++) if (held[i] && req[i]) return held;
    for (int i = 0; i < n; i++) if (req[i] && !blk[i]) return 4'(1 << i);
    return 4'b0;
  endfunction

  function automatic logic [4:0] ext_model(input logic [3:0] ack, input logic mode,
                                           input logic [3:0] req, input logic dram,
                                           input logic cfg);
    logic eff, blk, r;
    logic [3:0] m;
    eff = (ack == 4'b0) ? cfg : mode;
    if (eff) return {eff, pick(req, ack, 4'b0, 4)};
    blk = (ack[2] & req[2]) | (ack[3] & req[3] & dram);
    r   = req[0] & (ack[0] | ~blk);
    m   = pick({1'b0, req[3:1]}, {1'b0, ack[3:1]}, {1'b0, r & dram, r, 1'b0}, 3);
    return {eff, m[2:0], r};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] e_int, e_ext, n_int, n_ext;
    logic       e_mode;
    logic [4:0] em;
    int unsigned seed_ret;
    seed_ret = $urandom(32'd7719);
    drop_all();
    cfg_ref_serial = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", 8'h00);
    req_cpu = 1; req_xdma = 1;
    @(negedge clk);
    chk("R1 reset holds grants low", 8'h00);
    drop_all();
    rst_n = 1;
    repeat (4) tick();
    chk("R1 after release", 8'h00);

    // R2 / R3: all four together
    req_xdma = 1; req_dma = 1; req_dtc = 1; req_cpu = 1;
    tick(); chk("R2 R3 xdma wins internal", 8'b0001_0000);
    // R4 holder not pre-empted, handoff on drop
    req_xdma = 0; tick(); chk("R4 handoff to dma", 8'b0010_0000);
    req_xdma = 1; tick(); chk("R4 dma keeps over xdma", 8'b0010_0000);
    req_xdma = 0; req_dma = 0; req_dtc = 0; tick(); chk("R2 cpu granted", 8'b1000_0000);
    req_cpu = 0; tick(); chk("R5 grant falls after drop", 8'h00);

    // R7 owner gating
    mst_xreq = 1; tick(); chk("R7 no owner, no mst grant", 8'h00);
    req_cpu = 1; tick(); chk("R7 owner gained this edge", 8'b1000_0000);
    tick(); chk("R7 mst granted with owner", 8'b1000_1000);

    // R6 serialized order with a held mst
    ref_req = 1; rel_req = 1; xdma_xreq = 1;
    tick(); chk("R4 R6 mst keeps external", 8'b1000_1000);
    mst_xreq = 0; tick(); chk("R6 ref first", 8'b1000_0001);
    ref_req = 0; tick(); chk("R6 xdma second", 8'b1000_0010);
    xdma_xreq = 0; tick(); chk("R6 rel third", 8'b1000_0100);
    rel_req = 0; tick(); chk("R5 external idle", 8'b1000_0000);

    // R8 / R10 shared mode
    cfg_ref_serial = 0;
    ref_req = 1; xdma_xreq = 1; mst_xreq = 1; mst_dram = 0;
    tick(); chk("R8 R10 ref with xdma, mst waits", 8'b1000_0011);
    xdma_xreq = 0; tick(); chk("R8 ref with non-DRAM mst", 8'b1000_1001);
    ref_req = 0; mst_xreq = 0; tick(); chk("R5 shared idle", 8'b1000_0000);

    // R9 conflicts
    mst_dram = 1; mst_xreq = 1; ref_req = 1;
    tick(); chk("R9 ref beats DRAM mst", 8'b1000_0001);
    ref_req = 0; tick(); chk("R9 DRAM mst after ref", 8'b1000_1000);
    ref_req = 1; tick(); chk("R9 ref waits for DRAM mst", 8'b1000_1000);
    mst_xreq = 0; mst_dram = 0; tick(); chk("R9 ref after DRAM mst", 8'b1000_0001);
    rel_req = 1; tick(); chk("R9 rel waits for ref", 8'b1000_0001);
    ref_req = 0; tick(); chk("R9 R10 rel after ref", 8'b1000_0100);
    rel_req = 0; tick(); chk("R5 idle again", 8'b1000_0000);

    // R11 deferred mode change
    ref_req = 1; tick(); chk("R11 ref alone", 8'b1000_0001);
    cfg_ref_serial = 1; mst_xreq = 1;
    tick(); chk("R11 old shared mode still in force", 8'b1000_1001);
    ref_req = 0; mst_xreq = 0; tick(); chk("R11 idle", 8'b1000_0000);
    ref_req = 1; mst_xreq = 1; tick(); chk("R11 serialized now", 8'b1000_0001);
    ref_req = 0; mst_xreq = 0; tick(); tick();

    // R12 both domains for xdma
    req_cpu = 0; req_xdma = 1; xdma_xreq = 1;
    tick(); chk("R12 xdma holds both", 8'b0001_0010);
    drop_all(); tick(); tick();
    chk("R5 all idle before random", 8'h00);

    // random phase against the model
    e_int = 0; e_ext = 0; e_mode = cfg_ref_serial;
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 4 == 0) req_xdma = ~req_xdma;
      if ($urandom % 4 == 0) req_dma = ~req_dma;
      if ($urandom % 4 == 0) req_dtc = ~req_dtc;
      if ($urandom % 3 == 0) req_cpu = ~req_cpu;
      if ($urandom % 4 == 0) ref_req = ~ref_req;
      if ($urandom % 4 == 0) xdma_xreq = ~xdma_xreq;
      if ($urandom % 5 == 0) rel_req = ~rel_req;
      if ($urandom % 3 == 0) mst_xreq = ~mst_xreq;
      if ($urandom % 6 == 0) mst_dram = ~mst_dram;
      if ($urandom % 24 == 0) cfg_ref_serial = ~cfg_ref_serial;
      n_int = pick({req_cpu, req_dtc, req_dma, req_xdma}, e_int, 4'b0, 4);
      em = ext_model(e_ext, e_mode,
                     {mst_xreq & (|e_int[3:1]), rel_req, xdma_xreq, ref_req},
                     mst_dram, cfg_ref_serial);
      n_ext = em[3:0];
      tick();
      e_int = n_int; e_ext = n_ext; e_mode = em[4];
      chk("R2 R4 R6 R8 R9 R10 random", {e_int, e_ext});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule